// File: doc/BRIEF.md
# Ring Echo Retry Node

This block is one node's transmit and receive agent on a unidirectional ring of 18-bit flits where every delivery is confirmed by an echo. A packet is a header flit followed by a fixed number of data flits. An echo is a single header flit. The destination node takes the packet off the ring and writes an echo header into the slot the header used. The data slots behind it are left empty. The echo travels on to the sender. A positive echo releases the sender's stored copy. A negative echo makes the sender put the same packet on the ring again, with no action by the local client.

On the receive side the node delivers accepted packets to a small queue that the local client drains. It refuses packets with a negative echo while that queue is full. All traffic addressed to other nodes is forwarded unchanged. On the transmit side, packets from the local client are stored in a small set of slots until their echo arrives. A packet enters the ring only in a cycle with nothing to forward. Flits that arrive while a packet is being sent wait in a short insertion buffer.

Top module: `ring_echo_node`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ring_out_vld` and `rx_valid` are low and `tx_ready` is high.
- R2: A header flit carries its kind in bits [17:16], the destination in [15:12], the source in [11:8] and a tag in [7:0]. Kind 0 is a packet header, which is followed by 3 data flits. Kinds 1, 2 and 3 are single flits. A packet (kind 0) or an echo (kind 1 or 2) whose destination is not `NODE_ID`, and any kind 3 flit, is forwarded in arrival order with every bit unchanged. This takes one cycle when nothing is waiting ahead of it.
- R3: A kind 0 header addressed to `NODE_ID` that arrives while the receive queue has room is replaced on the ring by a positive echo. That echo has kind 1, destination equal to the packet's source, source `NODE_ID` and the same tag. The 3 data flits are removed from the ring. The packet appears at the receive port with its source and with data flit k in `rx_data[18k+17:18k]`.
- R4: A kind 0 header addressed to `NODE_ID` that arrives while the queue holds `RX_DEPTH` packets (counting one still being received) is replaced by a negative echo. It has kind 2 and the same destination, source and tag fields as a positive echo would. Its data flits are removed, and the queue contents are unchanged. Once an entry is popped, the next such header is accepted.
- R5: The receive port presents packets in arrival order. It holds `rx_valid`, `rx_src` and `rx_data` stable until a cycle with `rx_ready` high.
- R6: A packet accepted at the transmit port goes onto the ring as a kind 0 header, with destination `tx_dst`, source `NODE_ID` and tag equal to the index of the slot it occupies. The lowest free slot is used. The header is followed in consecutive cycles by `tx_data[17:0]`, `[35:18]` and `[53:36]`.
- R7: A kind 1 echo addressed to `NODE_ID` whose tag names a slot awaiting its echo frees that slot. The echo is removed from the ring.
- R8: A kind 2 echo addressed to `NODE_ID` whose tag names a slot awaiting its echo is removed from the ring. The stored packet is then sent again with identical flits.
- R9: `tx_ready` is low while all `TX_SLOTS` slots hold packets. A request made in that state is neither stored nor sent.
- R10: Forwarded traffic has priority. A packet starts only in a cycle with no forwarding backlog and nothing from the input to forward. Flits arriving while a packet is being sent are forwarded intact and in order right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_vld | input | 1 | Upstream ring slot carries a flit |
| ring_in_flit | input | 18 | Upstream flit |
| ring_out_vld | output | 1 | Downstream ring slot carries a flit |
| ring_out_flit | output | 18 | Downstream flit |
| tx_valid | input | 1 | Local client offers a packet |
| tx_ready | output | 1 | A transmit slot is free |
| tx_dst | input | 4 | Destination node of the offered packet |
| tx_data | input | 54 | Three data flits of the offered packet |
| rx_valid | output | 1 | A received packet is available |
| rx_ready | input | 1 | Local client takes the packet |
| rx_src | output | 4 | Source node of the received packet |
| rx_data | output | 54 | Three data flits of the received packet |

## Verification
The bench builds the node with its defaults: node 3, three data flits, two transmit slots and a two-entry receive queue. With these small depths, three addressed packets are enough to reach a negative echo, and two requests are enough to stall the transmit port. Timed directed sequences line up a packet request with a passing packet in both orders. This exercises the insertion buffer and the forwarding priority. A seeded random stream of foreign packets and echoes with random gaps checks that forwarded flits are never altered or reordered.

// File: rtl/ring_echo_node.sv
module ring_echo_node #(
  parameter int NODE_ID    = 3,
  parameter int ID_W       = 4,
  parameter int FLIT_W     = 18,
  parameter int DATA_FLITS = 3,
  parameter int TX_SLOTS   = 2,
  parameter int RX_DEPTH   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ring_in_vld,
  input  logic [FLIT_W-1:0]            ring_in_flit,
  output logic                         ring_out_vld,
  output logic [FLIT_W-1:0]            ring_out_flit,
  input  logic                         tx_valid,
  output logic                         tx_ready,
  input  logic [ID_W-1:0]              tx_dst,
  input  logic [FLIT_W*DATA_FLITS-1:0] tx_data,
  output logic                         rx_valid,
  input  logic                         rx_ready,
  output logic [ID_W-1:0]              rx_src,
  output logic [FLIT_W*DATA_FLITS-1:0] rx_data
);
  localparam int TAG_W = FLIT_W - 2 - 2*ID_W;
  localparam int PAY_W = FLIT_W * DATA_FLITS;
  localparam int CNT_W = $clog2(DATA_FLITS + 1);
  localparam int FWD_DEPTH = DATA_FLITS + 1;
  localparam int FP_W = $clog2(FWD_DEPTH);
  localparam int FC_W = $clog2(FWD_DEPTH + 1);
  localparam int SL_W = (TX_SLOTS > 1) ? $clog2(TX_SLOTS) : 1;
  localparam int RX_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam logic [1:0] K_DATA = 2'd0, K_ACK = 2'd1, K_NAK = 2'd2;
  localparam logic [1:0] M_PASS = 2'd0, M_TAKE = 2'd1, M_DROP = 2'd2;
  localparam logic [1:0] S_FREE = 2'd0, S_PEND = 2'd1, S_WAIT = 2'd2;
  localparam logic [ID_W-1:0] ME = ID_W'(NODE_ID);

  function automatic logic [FLIT_W-1:0] mk_hdr(input logic [1:0] k, input logic [ID_W-1:0] d,
                                               input logic [ID_W-1:0] s, input logic [TAG_W-1:0] t);
    return {k, d, s, t};
  endfunction

  // input decode
  wire [1:0]       in_kind = ring_in_flit[FLIT_W-1 -: 2];
  wire [ID_W-1:0]  in_dst  = ring_in_flit[FLIT_W-3 -: ID_W];
  wire [ID_W-1:0]  in_src  = ring_in_flit[FLIT_W-3-ID_W -: ID_W];
  wire [TAG_W-1:0] in_tag  = ring_in_flit[TAG_W-1:0];

  logic [CNT_W-1:0] in_left;
  logic [1:0]       in_mode;
  logic [RX_W:0]    rx_used;

  wire in_hdr   = ring_in_vld && (in_left == '0);
  wire body     = ring_in_vld && (in_left != '0);
  wire for_me   = (in_dst == ME);
  wire hdr_data = in_hdr && (in_kind == K_DATA);
  wire rx_room  = rx_used < (RX_W+1)'(RX_DEPTH);
  wire take     = hdr_data && for_me && rx_room;
  wire nak      = hdr_data && for_me && !rx_room;
  wire echo_me  = in_hdr && for_me && (in_kind == K_ACK || in_kind == K_NAK);
  wire new_vld  = (in_hdr && !echo_me) || (body && in_mode == M_PASS);
  wire [FLIT_W-1:0] new_flit = (take || nak) ? mk_hdr(take ? K_ACK : K_NAK, in_src, ME, in_tag)
                                             : ring_in_flit;
  wire [CNT_W-1:0] in_idx = CNT_W'(DATA_FLITS) - in_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_left <= '0;
      in_mode <= M_PASS;
    end else if (hdr_data) begin
      in_left <= CNT_W'(DATA_FLITS);
      in_mode <= take ? M_TAKE : (nak ? M_DROP : M_PASS);
    end else if (body) begin
      in_left <= in_left - 1'b1;
    end
  end

  // receive queue
  logic [PAY_W-1:0]    rx_mem  [RX_DEPTH];
  logic [ID_W-1:0]     rx_srcm [RX_DEPTH];
  logic [RX_DEPTH-1:0] rx_done;
  logic [RX_W-1:0]     rx_wp, rx_rp, rx_fill;

  function automatic logic [RX_W-1:0] rx_nxt(input logic [RX_W-1:0] p);
    return (p == RX_W'(RX_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign rx_valid = rx_done[rx_rp];
  assign rx_src   = rx_srcm[rx_rp];
  assign rx_data  = rx_mem[rx_rp];
  wire rx_pop = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_fill <= '0; rx_used <= '0; rx_done <= '0;
    end else begin
      if (take) begin
        rx_srcm[rx_wp] <= in_src;
        rx_fill <= rx_wp;
        rx_wp <= rx_nxt(rx_wp);
      end
      if (body && in_mode == M_TAKE) begin
        rx_mem[rx_fill][int'(in_idx)*FLIT_W +: FLIT_W] <= ring_in_flit;
        if (in_left == CNT_W'(1)) rx_done[rx_fill] <= 1'b1;
      end
      if (rx_pop) begin
        rx_done[rx_rp] <= 1'b0;
        rx_rp <= rx_nxt(rx_rp);
      end
      rx_used <= rx_used + (RX_W+1)'(take) - (RX_W+1)'(rx_pop);
    end
  end

  // transmit slots
  logic [1:0]      sl_st  [TX_SLOTS];
  logic [ID_W-1:0] sl_dst [TX_SLOTS];
  logic [PAY_W-1:0] sl_pay [TX_SLOTS];
  logic [SL_W-1:0] free_idx, pend_idx, inj_slot;
  logic            any_free, any_pend, inj_on, inj_go;
  logic [CNT_W-1:0] inj_idx;

  always_comb begin
    free_idx = '0; any_free = 1'b0; pend_idx = '0; any_pend = 1'b0;
    for (int i = TX_SLOTS-1; i >= 0; i--) begin
      if (sl_st[i] == S_FREE) begin any_free = 1'b1; free_idx = SL_W'(i); end
      if (sl_st[i] == S_PEND) begin any_pend = 1'b1; pend_idx = SL_W'(i); end
    end
  end

  assign tx_ready = any_free;
  wire tx_acc = tx_valid && tx_ready;
  wire [SL_W-1:0] esl = SL_W'(in_tag);
  wire echo_ok = echo_me && (in_tag < TAG_W'(TX_SLOTS)) && (sl_st[esl] == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TX_SLOTS; i++) sl_st[i] <= S_FREE;
      inj_on <= 1'b0; inj_slot <= '0; inj_idx <= '0;
    end else begin
      if (tx_acc) begin
        sl_st[free_idx]  <= S_PEND;
        sl_dst[free_idx] <= tx_dst;
        sl_pay[free_idx] <= tx_data;
      end
      if (inj_go) begin
        sl_st[pend_idx] <= S_WAIT;
        inj_on <= 1'b1; inj_slot <= pend_idx; inj_idx <= '0;
      end else if (inj_on) begin
        inj_idx <= inj_idx + 1'b1;
        if (inj_idx == CNT_W'(DATA_FLITS-1)) inj_on <= 1'b0;
      end
      if (echo_ok) sl_st[esl] <= (in_kind == K_ACK) ? S_FREE : S_PEND;
    end
  end

  // insertion buffer and output select
  logic [FLIT_W-1:0] fwd_mem [FWD_DEPTH];
  logic [FP_W-1:0]   fwd_wp, fwd_rp;
  logic [FC_W-1:0]   fwd_cnt;
  logic              f_push, f_pop, o_vld;
  logic [FLIT_W-1:0] o_flit;

  function automatic logic [FP_W-1:0] f_nxt(input logic [FP_W-1:0] p);
    return (p == FP_W'(FWD_DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    o_vld = 1'b0; o_flit = '0; f_push = 1'b0; f_pop = 1'b0; inj_go = 1'b0;
    if (inj_on) begin
      o_vld = 1'b1; o_flit = sl_pay[inj_slot][int'(inj_idx)*FLIT_W +: FLIT_W]; f_push = new_vld;
    end else if (fwd_cnt != '0) begin
      o_vld = 1'b1; o_flit = fwd_mem[fwd_rp]; f_pop = 1'b1; f_push = new_vld;
    end else if (new_vld) begin
      o_vld = 1'b1; o_flit = new_flit;
    end else if (any_pend) begin
      o_vld = 1'b1; o_flit = mk_hdr(K_DATA, sl_dst[pend_idx], ME, TAG_W'(pend_idx)); inj_go = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_wp <= '0; fwd_rp <= '0; fwd_cnt <= '0;
      ring_out_vld <= 1'b0; ring_out_flit <= '0;
    end else begin
      if (f_push) begin fwd_mem[fwd_wp] <= new_flit; fwd_wp <= f_nxt(fwd_wp); end
      if (f_pop) fwd_rp <= f_nxt(fwd_rp);
      fwd_cnt <= fwd_cnt + FC_W'(f_push) - FC_W'(f_pop);
      ring_out_vld  <= o_vld;
      ring_out_flit <= o_flit;
    end
  end

  p_rx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_used <= (RX_W+1)'(RX_DEPTH));
  p_nak_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nak && !inj_on && fwd_cnt == '0 |=> ring_out_vld && ring_out_flit[FLIT_W-1 -: 2] == K_NAK);
  p_ack_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !inj_on && fwd_cnt == '0 |=> ring_out_vld && ring_out_flit[FLIT_W-1 -: 2] == K_ACK
      && ring_out_flit[FLIT_W-3 -: ID_W] == $past(in_src));
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_src) && $stable(rx_data));
  p_fwd_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_cnt <= FC_W'(FWD_DEPTH));
  p_inj_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_on |=> ring_out_vld);
endmodule

// File: tb/ring_echo_node_bench.sv
module ring_echo_node_bench;
  localparam logic [3:0] ME = 4'd3;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ring_in_vld = 1'b0, ring_out_vld, tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic [17:0] ring_in_flit = '0, ring_out_flit;
  logic [3:0]  tx_dst = '0, rx_src;
  logic [53:0] tx_data = '0, rx_data;

  ring_echo_node #(.NODE_ID(3)) u_ring_echo_node (
    .clk(clk), .rst_n(rst_n), .ring_in_vld(ring_in_vld), .ring_in_flit(ring_in_flit),
    .ring_out_vld(ring_out_vld), .ring_out_flit(ring_out_flit), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_dst(tx_dst), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_src(rx_src), .rx_data(rx_data));

  int checks = 0, errors = 0, mchecks = 0, merrs = 0, cyc = 0;
  string req = "R1";
  logic [17:0] exp_q[$];
  logic [17:0] e_f;

  function automatic logic [17:0] hdr(input logic [1:0] k, input logic [3:0] d, input logic [3:0] s,
                                      input logic [7:0] t);
    return {k, d, s, t};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ring_out_vld) begin
      mchecks++;
      if (exp_q.size() == 0) begin
        merrs++;
        $display("FAIL %s unexpected flit actual=%0h expected=none", req, ring_out_flit);
      end else begin
        e_f = exp_q.pop_front();
        if (ring_out_flit !== e_f) begin
          merrs++;
          $display("FAIL %s ring flit actual=%0h expected=%0h", req, ring_out_flit, e_f);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL %s watchdog actual=%0d expected=done", req, cyc);
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrs + 1);
      $finish;
    end
  end

  task automatic drain(input string r);
    int n = 0;
    while (exp_q.size() != 0 && n < 80) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing flits actual=%0d expected=0", r, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic ring_flit(input logic [17:0] f);
    @(negedge clk); ring_in_vld = 1'b1; ring_in_flit = f;
  endtask

  task automatic ring_idle();
    @(negedge clk); ring_in_vld = 1'b0; ring_in_flit = '0;
  endtask

  task automatic send_pkt(input logic [17:0] h, input logic [53:0] d);
    ring_flit(h);
    for (int k = 0; k < 3; k++) ring_flit(d[18*k +: 18]);
    ring_idle();
  endtask

  task automatic push_pkt(input logic [17:0] h, input logic [53:0] d);
    exp_q.push_back(h);
    for (int k = 0; k < 3; k++) exp_q.push_back(d[18*k +: 18]);
  endtask

  task automatic tx_send(input logic [3:0] d, input logic [53:0] p);
    @(negedge clk); tx_valid = 1'b1; tx_dst = d; tx_data = p;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic rx_pop1();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  function automatic logic [53:0] rnd_pay();
    return {18'($urandom), 18'($urandom), 18'($urandom)};
  endfunction

  initial begin
    logic [53:0] pa, pb, pc, pd;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", ring_out_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 ring_out_vld", ring_out_vld, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);

    req = "R2";
    pa = rnd_pay();
    push_pkt(hdr(2'd0, 4'd5, 4'd9, 8'h11), pa);
    send_pkt(hdr(2'd0, 4'd5, 4'd9, 8'h11), pa);
    exp_q.push_back(hdr(2'd1, 4'd7, 4'd2, 8'h04));
    ring_flit(hdr(2'd1, 4'd7, 4'd2, 8'h04)); ring_idle();
    exp_q.push_back(hdr(2'd3, ME, 4'd2, 8'h05));
    ring_flit(hdr(2'd3, ME, 4'd2, 8'h05)); ring_idle();
    drain("R2 pass-through");

    req = "R3";
    pa = rnd_pay(); pb = rnd_pay(); pc = rnd_pay();
    exp_q.push_back(hdr(2'd1, 4'd7, ME, 8'h21));
    send_pkt(hdr(2'd0, ME, 4'd7, 8'h21), pa);
    drain("R3 first ack");
    chk("R3 rx_valid", rx_valid, 1);
    chk("R3 rx_src", rx_src, 7);
    chk("R3 rx_data", rx_data, pa);
    exp_q.push_back(hdr(2'd1, 4'd9, ME, 8'h22));
    send_pkt(hdr(2'd0, ME, 4'd9, 8'h22), pb);
    drain("R3 second ack");
    req = "R4";
    exp_q.push_back(hdr(2'd2, 4'd10, ME, 8'h23));
    send_pkt(hdr(2'd0, ME, 4'd10, 8'h23), pc);
    drain("R4 nak when full");
    req = "R5";
    chk("R5 head src held", rx_src, 7);
    chk("R5 head data held", rx_data, pa);
    rx_pop1();
    chk("R5 second valid", rx_valid, 1);
    chk("R5 second src", rx_src, 9);
    chk("R5 second data", rx_data, pb);
    rx_pop1();
    chk("R4 refused packet not queued", rx_valid, 0);
    req = "R4";
    pd = rnd_pay();
    exp_q.push_back(hdr(2'd1, 4'd10, ME, 8'h24));
    send_pkt(hdr(2'd0, ME, 4'd10, 8'h24), pd);
    drain("R4 accepted after pop");
    chk("R4 retry src", rx_src, 10);
    chk("R4 retry data", rx_data, pd);
    rx_pop1();

    req = "R6";
    pa = rnd_pay();
    chk("R6 tx_ready", tx_ready, 1);
    push_pkt(hdr(2'd0, 4'd6, ME, 8'd0), pa);
    tx_send(4'd6, pa);
    drain("R6 injection");
    req = "R7";
    ring_flit(hdr(2'd1, ME, 4'd6, 8'd0)); ring_idle();
    drain("R7 ack consumed no resend");
    chk("R7 tx_ready after ack", tx_ready, 1);

    req = "R8";
    pb = rnd_pay();
    push_pkt(hdr(2'd0, 4'd12, ME, 8'd0), pb);
    tx_send(4'd12, pb);
    drain("R8 first send reuses slot 0");
    push_pkt(hdr(2'd0, 4'd12, ME, 8'd0), pb);
    ring_flit(hdr(2'd2, ME, 4'd12, 8'd0)); ring_idle();
    drain("R8 retransmission");
    ring_flit(hdr(2'd1, ME, 4'd12, 8'd0)); ring_idle();
    drain("R7 free after retry");

    req = "R9";
    pa = rnd_pay(); pb = rnd_pay(); pc = rnd_pay();
    push_pkt(hdr(2'd0, 4'd1, ME, 8'd0), pa);
    push_pkt(hdr(2'd0, 4'd2, ME, 8'd1), pb);
    tx_send(4'd1, pa);
    tx_send(4'd2, pb);
    drain("R9 two slots");
    chk("R9 tx_ready low when full", tx_ready, 0);
    @(negedge clk); tx_valid = 1'b1; tx_dst = 4'd4; tx_data = pc;
    repeat (3) @(negedge clk); tx_valid = 1'b0;
    drain("R9 no send while full");
    ring_flit(hdr(2'd1, ME, 4'd2, 8'd1)); ring_idle();
    @(negedge clk);
    chk("R9 tx_ready after freeing slot 1", tx_ready, 1);
    ring_flit(hdr(2'd1, ME, 4'd1, 8'd0)); ring_idle();
    drain("R9 echoes consumed");

    req = "R10";
    pa = rnd_pay(); pb = rnd_pay();
    push_pkt(hdr(2'd0, 4'd8, 4'd1, 8'h31), pa);
    push_pkt(hdr(2'd0, 4'd11, ME, 8'd0), pb);
    @(negedge clk); tx_valid = 1'b1; tx_dst = 4'd11; tx_data = pb;
    ring_in_vld = 1'b1; ring_in_flit = hdr(2'd0, 4'd8, 4'd1, 8'h31);
    @(negedge clk); tx_valid = 1'b0; ring_in_flit = pa[17:0];
    @(negedge clk); ring_in_flit = pa[35:18];
    @(negedge clk); ring_in_flit = pa[53:36];
    ring_idle();
    drain("R10 pass before inject");
    ring_flit(hdr(2'd1, ME, 4'd11, 8'd0)); ring_idle();
    drain("R10 free");
    pa = rnd_pay(); pb = rnd_pay();
    push_pkt(hdr(2'd0, 4'd13, ME, 8'd0), pb);
    push_pkt(hdr(2'd0, 4'd14, 4'd0, 8'h41), pa);
    tx_send(4'd13, pb);
    send_pkt(hdr(2'd0, 4'd14, 4'd0, 8'h41), pa);
    drain("R10 insertion buffer");
    ring_flit(hdr(2'd1, ME, 4'd13, 8'd0)); ring_idle();
    drain("R10 free");

    req = "R2 random";
    for (int n = 0; n < 300; n++) begin
      logic [3:0] d;
      logic [17:0] h;
      int pick;
      d = 4'($urandom_range(0, 15));
      if (d == ME) d = 4'd4;
      pick = $urandom_range(0, 5);
      if (pick < 3) begin
        h = hdr(2'd0, d, 4'($urandom), 8'($urandom));
        pa = rnd_pay();
        push_pkt(h, pa);
        ring_flit(h);
        for (int k = 0; k < 3; k++) ring_flit(pa[18*k +: 18]);
      end else if (pick == 3) begin
        h = hdr(2'($urandom_range(1, 2)), d, 4'($urandom), 8'($urandom));
        exp_q.push_back(h);
        ring_flit(h);
      end else if (pick == 4) begin
        h = hdr(2'd3, 4'($urandom), 4'($urandom), 8'($urandom));
        exp_q.push_back(h);
        ring_flit(h);
      end else begin
        repeat ($urandom_range(1, 3)) ring_idle();
      end
    end
    ring_idle();
    drain("R2 random stream");

    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrs);
    $finish;
  end
endmodule